// File: doc/BRIEF.md
# Sector Write-Protect Unlock Sequencer

This block sits beside a word-addressed memory array and watches every access that goes to it. Each access is offered as one beat on a valid/ready stream: a read or write flag, the word address, and the low data byte. The block never applies back-pressure. `acc_ready` is held high, so every beat with `acc_valid` high is taken in the cycle it is offered. For each write it decides, in the same cycle, whether the array may store it. It drives `arr_we` for a write that may be stored. When it blocks a write, it raises `wr_block` for one cycle afterwards.

The address space is split into eight equal sectors, and the top three address bits pick the sector. An 8-bit protect register holds one bit per sector. A 1 blocks writes to that sector, and a 0 lets them through. The register changes only through an unlock ritual, which has three parts:
- exactly six reads at parameter-chosen key addresses, in their set order;
- one write whose low byte is the new protect value;
- one more write whose low byte is its bitwise complement.

Any deviation quietly restarts the matching. The key reads are still ordinary reads of the array. The two ritual writes are taken by the block and never reach the array.

The protect register has no reset, which models settings that survive power loss. Its value at start-up is a parameter.

Top module: `wp_unlock_guard`

## Requirements
- R1: A write is sector-blocked when the protect bit for its sector is 1. The sector is `acc_addr[17:15]`, and bit n of `prot_o` guards sector n. A sector-blocked write keeps `arr_we` low and drives `wr_block` high in the next cycle only. A write to a sector whose bit is 0, and which is not a ritual write, drives `arr_we` high in the same cycle and leaves `wr_block` low.
- R2: `acc_ready` is always 1. A read never drives `arr_we` or `wr_block`, whatever the protect bits are.
- R3: The default key addresses are, in order: 0x3C0F0, 0x0F3C3, 0x2A555, 0x155AA, 0x30C3C, 0x0A0F5. After these six reads, a write with low byte V followed by a write with low byte ~V makes `prot_o` equal V from the cycle after the second write. The addresses of the two writes are ignored. The very next access already sees the new value.
- R4: A second write whose low byte is not ~V leaves `prot_o` unchanged. It also restarts the matching, so a later complete ritual still works.
- R5: While the key is being matched, either of the following returns the matcher to its start: a read at an address other than the next key address, or any write. Such a write is handled as a normal array write.
- R6: A read in place of the value write (a seventh read) aborts the ritual. The writes that follow are normal array writes, and `prot_o` does not change.
- R7: Both the value write and the complement write, whether the complement is right or wrong, keep `arr_we` low and do not raise `wr_block`, even in a protected sector.
- R8: `prot_o` starts at parameter `PROT_INIT` (default 0x81) and is not changed by `rst`. `rst` returns the matcher to its start and clears `wr_block`.
- R9: Cycles with `acc_valid` low neither advance nor restart the matcher, and drive neither `arr_we` nor `wr_block`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of matcher and flag |
| acc_valid | input | 1 | Access beat present |
| acc_ready | output | 1 | Beat accepted (always 1) |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 18 | Word address of the access |
| acc_data | input | 8 | Low data byte of a write |
| arr_we | output | 1 | Array may store this write (same cycle) |
| wr_block | output | 1 | A write was sector-blocked in the previous cycle |
| prot_o | output | 8 | Per-sector protect bits |

## Verification
Two events can fall in the same cycle. The first is a ritual write aimed at a protected sector: that one cycle could be treated either as protection blocking or as ritual consumption. The bench aims both ritual writes at protected sectors and expects no `wr_block` and no `arr_we`. The second is a protect update followed at once by an array write. Right after the complement write, the bench writes to a sector whose bit has just turned on and expects that write to be blocked by the new value. A scoreboard judges both from a reference model of the ritual.

// File: rtl/wp_seq_pkg.sv
package wp_seq_pkg;
  typedef enum logic [1:0] {
    PH_KEY = 2'd0,   // matching key reads
    PH_VAL = 2'd1,   // expecting the value write
    PH_CMP = 2'd2    // expecting the complement write
  } phase_t;
endpackage

// File: rtl/wp_key_matcher.sv
module wp_key_matcher
  import wp_seq_pkg::*;
#(
  parameter int ADDR_W  = 18,
  parameter int DATA_W  = 8,
  parameter int KEY_LEN = 6,
  parameter logic [KEY_LEN*ADDR_W-1:0] KEY_SEQ = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fire,
  input  logic              is_write,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output logic              consume,
  output logic              commit,
  output logic [DATA_W-1:0] commit_val
);
  localparam int IDX_W = (KEY_LEN > 1) ? $clog2(KEY_LEN) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(KEY_LEN - 1);

  logic [ADDR_W-1:0] key_tab [KEY_LEN];

  // Unpack the key list; entry 0 sits in the lowest bits.
  for (genvar k = 0; k < KEY_LEN; k++) begin : g_key
    assign key_tab[k] = KEY_SEQ[k*ADDR_W +: ADDR_W];
  end

  phase_t            phase_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] val_q;
  logic              key_hit;

  assign key_hit    = (addr == key_tab[idx_q]);
  assign consume    = fire && is_write && (phase_q != PH_KEY);
  assign commit     = !rst && fire && is_write && (phase_q == PH_CMP) && (data == ~val_q);
  assign commit_val = val_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_KEY;
      idx_q   <= '0;
      val_q   <= '0;
    end else if (fire) begin
      unique case (phase_q)
        PH_KEY: begin
          if (!is_write && key_hit) begin
            if (idx_q == LAST) begin
              phase_q <= PH_VAL;
              idx_q   <= '0;
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end else begin
            idx_q <= '0;
          end
        end
        PH_VAL: begin
          if (is_write) begin
            val_q   <= data;
            phase_q <= PH_CMP;
          end else begin
            phase_q <= PH_KEY;
          end
        end
        default: phase_q <= PH_KEY;
      endcase
    end
  end
endmodule

// File: rtl/wp_prot_reg.sv
module wp_prot_reg #(
  parameter int NSECT = 8,
  parameter logic [NSECT-1:0] PROT_INIT = '0
) (
  input  logic             clk,
  input  logic             load,
  input  logic [NSECT-1:0] load_val,
  output logic [NSECT-1:0] prot
);
  // Retained settings: initial value only, no reset term.
  logic [NSECT-1:0] prot_q = PROT_INIT;

  always_ff @(posedge clk) begin
    if (load) prot_q <= load_val;
  end

  assign prot = prot_q;
endmodule

// File: rtl/wp_write_gate.sv
module wp_write_gate #(
  parameter int SECT_W = 3,
  parameter int NSECT  = 8
) (
  input  logic              fire,
  input  logic              is_write,
  input  logic [SECT_W-1:0] sector,
  input  logic              consume,
  input  logic [NSECT-1:0]  prot,
  output logic              arr_we,
  output logic              inhibit
);
  logic array_write;
  assign array_write = fire && is_write && !consume;
  assign arr_we      = array_write && !prot[sector];
  assign inhibit     = array_write &&  prot[sector];
endmodule

// File: rtl/wp_unlock_guard.sv
module wp_unlock_guard #(
  parameter int ADDR_W  = 18,
  parameter int SECT_W  = 3,
  parameter int KEY_LEN = 6,
  parameter logic [KEY_LEN*ADDR_W-1:0] KEY_SEQ = {
    18'h0A0F5, 18'h30C3C, 18'h155AA, 18'h2A555, 18'h0F3C3, 18'h3C0F0},
  parameter logic [(1<<SECT_W)-1:0] PROT_INIT = 8'h81
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     acc_valid,
  output logic                     acc_ready,
  input  logic                     acc_write,
  input  logic [ADDR_W-1:0]        acc_addr,
  input  logic [(1<<SECT_W)-1:0]   acc_data,
  output logic                     arr_we,
  output logic                     wr_block,
  output logic [(1<<SECT_W)-1:0]   prot_o
);
  localparam int NSECT = 1 << SECT_W;

  logic             fire, consume, commit, inhibit, blk_q;
  logic [NSECT-1:0] commit_val;

  assign acc_ready = 1'b1;
  assign fire      = acc_valid && acc_ready;

  wp_key_matcher #(
    .ADDR_W(ADDR_W), .DATA_W(NSECT), .KEY_LEN(KEY_LEN), .KEY_SEQ(KEY_SEQ)
  ) u_match (
    .clk(clk), .rst(rst), .fire(fire), .is_write(acc_write),
    .addr(acc_addr), .data(acc_data),
    .consume(consume), .commit(commit), .commit_val(commit_val)
  );

  wp_prot_reg #(.NSECT(NSECT), .PROT_INIT(PROT_INIT)) u_prot (
    .clk(clk), .load(commit), .load_val(commit_val), .prot(prot_o)
  );

  wp_write_gate #(.SECT_W(SECT_W), .NSECT(NSECT)) u_gate (
    .fire(fire), .is_write(acc_write), .sector(acc_addr[ADDR_W-1 -: SECT_W]),
    .consume(consume), .prot(prot_o), .arr_we(arr_we), .inhibit(inhibit)
  );

  always_ff @(posedge clk) begin
    if (rst) blk_q <= 1'b0;
    else     blk_q <= inhibit;
  end

  assign wr_block = blk_q;
endmodule

// File: rtl/wp_unlock_guard_chk.sv
module wp_unlock_guard_chk #(
  parameter int ADDR_W = 18,
  parameter int SECT_W = 3
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   acc_valid,
  input logic                   acc_write,
  input logic [ADDR_W-1:0]      acc_addr,
  input logic [(1<<SECT_W)-1:0] acc_data,
  input logic                   arr_we,
  input logic                   wr_block,
  input logic [(1<<SECT_W)-1:0] prot_o
);
  logic [SECT_W-1:0] sec;
  assign sec = acc_addr[ADDR_W-1 -: SECT_W];

  // R2
  read_no_we_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !acc_write) |-> !arr_we);

  // R1
  prot_block_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_write && prot_o[sec]) |-> !arr_we);

  // R1
  flag_cause_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_write && !prot_o[sec]) |=> !wr_block);

  // R3
  prot_cmp_chk: assert property (@(posedge clk) disable iff (rst)
    (prot_o != $past(prot_o)) |->
      ($past(acc_valid && acc_write) && ($past(acc_data) == ~prot_o)));

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !acc_valid |=> (!wr_block && $stable(prot_o)));
endmodule

bind wp_unlock_guard wp_unlock_guard_chk #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_chk (
  .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
  .acc_addr(acc_addr), .acc_data(acc_data), .arr_we(arr_we),
  .wr_block(wr_block), .prot_o(prot_o)
);

// File: tb/wp_unlock_guard_test.sv
`timescale 1ns/1ps
module wp_unlock_guard_test;
  logic clk = 1'b0, rst = 1'b1;
  logic acc_valid = 1'b0, acc_write = 1'b0;
  logic [17:0] acc_addr = '0;
  logic [7:0]  acc_data = '0;
  logic acc_ready, arr_we, wr_block;
  logic [7:0] prot_o;

  always #2.5 clk = ~clk;

  wp_unlock_guard uut (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_ready(acc_ready),
    .acc_write(acc_write), .acc_addr(acc_addr), .acc_data(acc_data),
    .arr_we(arr_we), .wr_block(wr_block), .prot_o(prot_o)
  );

  localparam logic [17:0] KEYS [6] = '{18'h3C0F0, 18'h0F3C3, 18'h2A555,
                                       18'h155AA, 18'h30C3C, 18'h0A0F5};

  typedef struct {
    bit obs_we, exp_we, obs_rdy, exp_flag;
    logic [7:0] exp_prot;
    string tag;
  } item_t;
  item_t sb[$];

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  // Reference model of the requirements
  int m_phase = 0, m_idx = 0;
  logic [7:0] m_val = '0, m_prot = 8'h81;

  task automatic fail(string tag, string what, int act, int exp);
    n_bad++;
    $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
  endtask

  task automatic do_acc(input bit v, input bit w, input logic [17:0] a,
                        input logic [7:0] d, input string tag);
    item_t it;
    bit cons;
    @(negedge clk);
    acc_valid = v; acc_write = w; acc_addr = a; acc_data = d;
    #1;
    it.obs_we  = arr_we;
    it.obs_rdy = acc_ready;
    cons = v && w && (m_phase != 0);
    it.exp_we   = v && w && !cons && !m_prot[a[17:15]];
    it.exp_flag = v && w && !cons &&  m_prot[a[17:15]];
    if (v) begin
      case (m_phase)
        0: if (!w && a == KEYS[m_idx]) begin
             if (m_idx == 5) begin m_phase = 1; m_idx = 0; end
             else m_idx++;
           end else m_idx = 0;
        1: if (w) begin m_val = d; m_phase = 2; end else m_phase = 0;
        default: begin
          if (w && d == ~m_val) m_prot = m_val;
          m_phase = 0;
        end
      endcase
    end
    it.exp_prot = m_prot;
    it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) do_acc(1'b0, 1'b0, 18'h0, 8'h0, tag);
  endtask

  task automatic keys(input int gaps, input string tag);
    for (int k = 0; k < 6; k++) begin
      do_acc(1'b1, 1'b0, KEYS[k], 8'h0, tag);
      if (gaps > 0) idle(gaps, "R9");
    end
  endtask

  task automatic pulse_reset();
    @(negedge clk);
    acc_valid = 1'b0; rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    m_phase = 0; m_idx = 0;
  endtask

  // Monitor: compares results one cycle after each access
  initial begin
    item_t it;
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        it = sb.pop_front();
        n_cmp++;
        if (it.obs_we != it.exp_we)   fail(it.tag, "arr_we", it.obs_we, it.exp_we);
        if (wr_block != it.exp_flag)  fail(it.tag, "wr_block", wr_block, it.exp_flag);
        if (prot_o != it.exp_prot)    fail(it.tag, "prot_o", prot_o, it.exp_prot);
        if (it.obs_rdy != 1'b1)       fail("R2", "acc_ready", it.obs_rdy, 1);
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    // R8 reset state
    n_cmp++;
    if (prot_o != 8'h81 || wr_block !== 1'b0 || arr_we !== 1'b0 || acc_ready !== 1'b1)
      fail("R8", "reset state prot_o", prot_o, 8'h81);

    // R1 protect decoding with initial 0x81
    do_acc(1, 1, 18'h00010, 8'hAA, "R1");
    do_acc(1, 1, 18'h08010, 8'hAA, "R1");
    do_acc(1, 1, 18'h3FFFF, 8'hAA, "R1");
    do_acc(1, 1, 18'h20000, 8'hAA, "R1");
    // R2 reads in protected sectors
    do_acc(1, 0, 18'h00020, 8'h00, "R2");
    do_acc(1, 0, 18'h38000, 8'h00, "R2");
    idle(2, "R9");

    // R3 / R9: unlock to 0x3C with idle gaps
    keys(1, "R3");
    do_acc(1, 1, 18'h01234, 8'h3C, "R7");
    do_acc(1, 1, 18'h3FFFF, 8'hC3, "R7");
    // R3 immediate use: sector 2 is now protected
    do_acc(1, 1, 18'h10000, 8'h11, "R3");
    do_acc(1, 1, 18'h00000, 8'h11, "R3");
    do_acc(1, 1, 18'h28000, 8'h11, "R1");

    // R4 wrong complement
    keys(0, "R4");
    do_acc(1, 1, 18'h00000, 8'h0F, "R4");
    do_acc(1, 1, 18'h00000, 8'hF1, "R4");
    do_acc(1, 1, 18'h08000, 8'h22, "R4");
    keys(0, "R4");
    do_acc(1, 1, 18'h00000, 8'h0F, "R4");
    do_acc(1, 1, 18'h00000, 8'hF0, "R4");
    do_acc(1, 1, 18'h20000, 8'h22, "R4");

    // R5 out-of-order read and inserted write
    for (int k = 0; k < 3; k++) do_acc(1, 0, KEYS[k], 8'h0, "R5");
    do_acc(1, 0, KEYS[4], 8'h0, "R5");
    for (int k = 3; k < 6; k++) do_acc(1, 0, KEYS[k], 8'h0, "R5");
    do_acc(1, 1, 18'h20000, 8'hAA, "R5");
    do_acc(1, 1, 18'h20000, 8'h55, "R5");
    for (int k = 0; k < 4; k++) do_acc(1, 0, KEYS[k], 8'h0, "R5");
    do_acc(1, 1, 18'h20000, 8'h99, "R5");
    for (int k = 4; k < 6; k++) do_acc(1, 0, KEYS[k], 8'h0, "R5");
    do_acc(1, 1, 18'h20000, 8'hAA, "R5");
    do_acc(1, 1, 18'h20000, 8'h55, "R5");

    // R6 seventh read
    keys(0, "R6");
    do_acc(1, 0, KEYS[0], 8'h0, "R6");
    do_acc(1, 1, 18'h20000, 8'h00, "R6");
    do_acc(1, 1, 18'h20000, 8'hFF, "R6");

    // R7 ritual writes into protected sectors, wrong complement too
    keys(0, "R7");
    do_acc(1, 1, 18'h00000, 8'h66, "R7");
    do_acc(1, 1, 18'h18000, 8'h12, "R7");
    keys(0, "R7");
    do_acc(1, 1, 18'h00000, 8'hF0, "R7");
    do_acc(1, 1, 18'h08000, 8'h0F, "R7");
    do_acc(1, 1, 18'h00000, 8'h01, "R7");

    // R8 reset keeps prot, restarts matcher
    pulse_reset();
    #1;
    n_cmp++;
    if (prot_o != m_prot) fail("R8", "prot_o after reset", prot_o, m_prot);
    for (int k = 0; k < 3; k++) do_acc(1, 0, KEYS[k], 8'h0, "R8");
    pulse_reset();
    for (int k = 3; k < 6; k++) do_acc(1, 0, KEYS[k], 8'h0, "R8");
    do_acc(1, 1, 18'h20000, 8'h00, "R8");
    do_acc(1, 1, 18'h20000, 8'hFF, "R8");
    keys(0, "R8");
    do_acc(1, 1, 18'h20000, 8'h00, "R8");
    do_acc(1, 1, 18'h20000, 8'hFF, "R8");
    do_acc(1, 1, 18'h38000, 8'h5A, "R8");

    idle(3, "R9");
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule